// File: doc/BRIEF.md
# Scan Line Replicating Video Capture

This block sits between a small retro computer's 8-bit output port and a VGA-style display path. The port is sampled once per pixel period, marked by a single-cycle pixel strobe. Each sampled byte holds a 6-bit colour field, a horizontal sync bit and a vertical sync bit. The block keeps its own frame line counter. On every fourth active line it captures the colour values into a line buffer. On the three lines that follow it replays those stored colours in place of the incoming ones. The source machine therefore only has to produce real pixels on one line in four and can spend the rest of its time computing.

The horizontal sync rising edge is the block's line event. On it the pointer into the line buffer returns to zero and the line counter advances. If vertical sync has fallen since the previous line event, the counter is also pulled to a fixed offset so that it tracks the source frame. As side effects of the same event, a 4-bit LED output and an 8-bit audio DAC value are loaded from the byte. A disable input turns replication off, so every line is captured and passed straight through.

Top module: `scanline_replicator`

## Requirements
- R1: While rst_n is low, all outputs (colour, both syncs, LEDs, DAC) go to zero on the next clock. The internal line counter and buffer pointer also return to zero, and the stored previous horizontal sync level becomes low.
- R2: Byte layout: colour in bits 5:0, horizontal sync in bit 6, vertical sync in bit 7. One clock after a strobe, hsync_o and vsync_o equal bits 6 and 7 of the strobed byte. Colour, hsync_o and vsync_o hold their values on cycles without a strobe.
- R3: A line event is a strobe whose byte has bit 6 set while the previous strobed byte (or the reset state) had it clear. Each line event advances the line counter by one, wrapping from 520 to 0, so a frame has 521 lines.
- R4: When the line counter is 480 or above, or its two low bits are zero, a strobed byte's colour appears on pix_col one clock later and is stored in the buffer at the current pointer.
- R5: Otherwise, pix_col one clock after the strobe is the colour stored at the current pointer, and the incoming colour is ignored and not stored.
- R6: The buffer pointer advances by one on each strobe, modulo 256. On a line event it is used for that strobe and then reset to zero.
- R7: Vertical sync is sampled at each line event; the reset value of that sample is high. If the previous sample was high and the current one is low, the counter is set to 485 and then advanced, so it reads 486.
- R8: On a line event, led_o takes bits 3:0 of the byte one clock later and holds it until the next line event.
- R9: On a line event, dac_o takes the byte with bits 3:0 cleared one clock later and holds it until the next line event.
- R10: While rep_off is high at a strobe, that strobe takes the R4 path regardless of the line counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_stb | input | 1 | One-cycle strobe marking a valid port sample |
| port_byte | input | 8 | Sampled port byte: colour, horizontal and vertical sync |
| rep_off | input | 1 | High forces capture and pass-through on every line |
| pix_col | output | 6 | Colour sent to the display |
| hsync_o | output | 1 | Horizontal sync to the display |
| vsync_o | output | 1 | Vertical sync to the display |
| led_o | output | 4 | LED pattern latched at each line event |
| dac_o | output | 8 | Audio DAC value latched at each line event |

## Verification
Every result of a strobe is due exactly one clock after that strobe: colour and both syncs on every strobe, LEDs and DAC only on line-event strobes. Changes to the line counter and pointer become visible only through the colour of later strobes. The bench drives inputs on the falling edge and advances its behavioural model there, which predicts the register values after the next rising edge. It compares them at the following falling edge, so every comparison lands one full clock after the stimulus it depends on. Idle gaps of varying length between strobes let the same per-clock comparison confirm that outputs hold.

// File: rtl/srep_pkg.sv
// Shared constants for the scan line replicator.
// Assumes an 8-bit port byte with colour in the low bits and syncs above it.
package srep_pkg;
    localparam int BYTE_W     = 8;    // port byte width
    localparam int COL_W      = 6;    // colour field width, starting at bit 0
    localparam int HS_BIT     = 6;    // horizontal sync bit position
    localparam int VS_BIT     = 7;    // vertical sync bit position
    localparam int LED_W      = 4;    // LED nibble width
    localparam int LED_LSB    = 0;    // LED nibble position inside the byte
    localparam int FRAME_LINES = 521; // lines per frame
    localparam int ACTIVE_LINES = 480; // lines with picture content
    localparam int RESYNC_LINE = 485; // counter value loaded on vertical sync fall
    localparam int REP_FACTOR  = 4;   // one captured line per this many
    localparam int BUF_DEPTH   = 256; // line buffer entries
endpackage

// File: rtl/srep_line_store.sv
// Line buffer: one write port and an asynchronous read at the same address.
// Assumes the caller never reads an entry before it has been written.
module srep_line_store #(
    parameter int DEPTH = 256,
    parameter int W     = 6,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Capture a colour value on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Replay read of the entry under the pointer.
    assign rdata = mem[addr];
endmodule

// File: rtl/srep_timing.sv
// Line timing: detects horizontal sync rising edges, keeps the buffer
// pointer and the frame line counter, and decides capture or replay.
// Assumes REP is a power of two and at least two; strobes are single-cycle.
module srep_timing #(
    parameter int LINES  = 521,
    parameter int ACTIVE = 480,
    parameter int RESYNC = 485,
    parameter int REP    = 4,
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(LINES),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int REP_W = $clog2(REP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             force_wr,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_o,
    output logic             rise_o
);
    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             prev_hs;
    logic             vs_at_edge;

    // Line event and capture decision for the current strobe.
    always_comb begin
        rise_o = stb && hs_in && !prev_hs;
        wr_o   = force_wr
              || (line_cnt[REP_W-1:0] == '0)
              || (line_cnt >= CNT_W'(ACTIVE));
    end

    // Counter value after an optional resync, then advanced with wrap.
    always_comb begin
        base_cnt = (vs_at_edge && !vs_in) ? CNT_W'(RESYNC) : line_cnt;
        next_cnt = (base_cnt == CNT_W'(LINES - 1)) ? '0 : base_cnt + 1'b1;
    end

    // Pointer, counter and sync history, updated on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt   <= '0;
            ptr_o      <= '0;
            prev_hs    <= 1'b0;
            vs_at_edge <= 1'b1;
        end else if (stb) begin
            prev_hs <= hs_in;
            if (rise_o) begin
                ptr_o      <= '0;
                vs_at_edge <= vs_in;
                line_cnt   <= next_cnt;
            end else begin
                ptr_o <= ptr_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scanline_replicator.sv
// Top level: captures one line in REP_FACTOR and replays it on the others,
// forwards syncs, and latches LED and DAC values at each line event.
// Assumes a port byte with colour at bit 0, syncs at HS_BIT and VS_BIT.
module scanline_replicator
    import srep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic [7:0]        port_byte,
    input  logic              rep_off,
    output logic [5:0]        pix_col,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic [3:0]        led_o,
    output logic [7:0]        dac_o
);
    localparam int PTR_W = $clog2(BUF_DEPTH);
    localparam logic [BYTE_W-1:0] LED_MASK =
        BYTE_W'(((1 << LED_W) - 1) << LED_LSB);

    logic [PTR_W-1:0] ptr;
    logic             wr_path;
    logic             line_evt;
    logic [COL_W-1:0] stored_col;
    logic [COL_W-1:0] chosen_col;

    srep_timing #(
        .LINES (FRAME_LINES),
        .ACTIVE(ACTIVE_LINES),
        .RESYNC(RESYNC_LINE),
        .REP   (REP_FACTOR),
        .DEPTH (BUF_DEPTH)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (pix_stb),
        .hs_in   (port_byte[HS_BIT]),
        .vs_in   (port_byte[VS_BIT]),
        .force_wr(rep_off),
        .ptr_o   (ptr),
        .wr_o    (wr_path),
        .rise_o  (line_evt)
    );

    srep_line_store #(
        .DEPTH(BUF_DEPTH),
        .W    (COL_W)
    ) u_store (
        .clk  (clk),
        .we   (pix_stb && wr_path),
        .addr (ptr),
        .wdata(port_byte[COL_W-1:0]),
        .rdata(stored_col)
    );

    // Pick live or stored colour for this strobe.
    assign chosen_col = wr_path ? port_byte[COL_W-1:0] : stored_col;

    // Register the display outputs on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_col <= '0;
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
        end else if (pix_stb) begin
            pix_col <= chosen_col;
            hsync_o <= port_byte[HS_BIT];
            vsync_o <= port_byte[VS_BIT];
        end
    end

    // Latch LED and DAC side outputs at each line event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_o <= '0;
            dac_o <= '0;
        end else if (line_evt) begin
            led_o <= port_byte[LED_LSB +: LED_W];
            dac_o <= port_byte & ~LED_MASK;
        end
    end
endmodule

// File: rtl/srep_checker.sv
// Port-level properties of the scan line replicator, bound to the top.
// Assumes the default byte layout (syncs at bits 6 and 7, LEDs at 3:0).
module srep_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_stb,
    input logic [7:0] port_byte,
    input logic       rep_off,
    input logic [5:0] pix_col,
    input logic       hsync_o,
    input logic       vsync_o,
    input logic [3:0] led_o,
    input logic [7:0] dac_o
);
    // Display outputs hold between strobes.
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> ($stable(pix_col) && $stable(hsync_o) && $stable(vsync_o)));

    // Syncs follow the strobed byte one clock later.
    assert_sync_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> (hsync_o == $past(port_byte[6]) && vsync_o == $past(port_byte[7])));

    // Forced capture passes the live colour through.
    assert_pass_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && rep_off) |=> (pix_col == $past(port_byte[5:0])));

    // LEDs take the low nibble at a line event.
    assert_led_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && port_byte[6] && !hsync_o) |=> (led_o == $past(port_byte[3:0])));

    // DAC takes the masked byte at a line event.
    assert_dac_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && port_byte[6] && !hsync_o) |=>
            (dac_o == {$past(port_byte[7:4]), 4'b0000}));

    // Side outputs hold without a strobe.
    assert_side_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> ($stable(led_o) && $stable(dac_o)));
endmodule

bind scanline_replicator srep_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_stb  (pix_stb),
    .port_byte(port_byte),
    .rep_off  (rep_off),
    .pix_col  (pix_col),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .led_o    (led_o),
    .dac_o    (dac_o)
);

// File: tb/scanline_replicator_bench.sv
module scanline_replicator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_PX    = 8;
    localparam int N_LINES    = 1200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_stb = 1'b0;
    logic [7:0] port_byte = 8'h00;
    logic       rep_off = 1'b0;
    logic [5:0] pix_col;
    logic       hsync_o;
    logic       vsync_o;
    logic [3:0] led_o;
    logic [7:0] dac_o;

    int total = 0;
    int bad = 0;

    // Reference model state
    int         m_line;
    int         m_ptr;
    bit         m_prevhs;
    bit         m_vsedge;
    logic [5:0] m_buf [256];
    logic [5:0] e_col;
    logic       e_hs, e_vs;
    logic [3:0] e_led;
    logic [7:0] e_dac;
    string      e_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scanline_replicator u_scanline_replicator (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .port_byte(port_byte),
        .rep_off(rep_off), .pix_col(pix_col), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .led_o(led_o), .dac_o(dac_o)
    );

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check(e_tag, {2'b00, pix_col}, {2'b00, e_col});
        check("R2 hsync", {7'd0, hsync_o}, {7'd0, e_hs});
        check("R2 vsync", {7'd0, vsync_o}, {7'd0, e_vs});
        check("R8 led", {4'd0, led_o}, {4'd0, e_led});
        check("R9 dac", dac_o, e_dac);
    endtask

    // Model one strobe: predicts the registers after the next rising edge.
    task automatic model(logic [7:0] b, bit off);
        bit wr, rise;
        wr = off || (m_line % 4 == 0) || (m_line >= 480);
        if (wr) begin
            m_buf[m_ptr] = b[5:0];
            e_col = b[5:0];
            e_tag = off ? "R10 forced pass" : "R4 capture";
        end else begin
            e_col = m_buf[m_ptr];
            e_tag = "R5 replay";
        end
        e_hs = b[6];
        e_vs = b[7];
        rise = b[6] && !m_prevhs;
        m_prevhs = b[6];
        if (rise) begin
            e_led = b[3:0];
            e_dac = {b[7:4], 4'b0000};
            if (m_vsedge && !b[7]) m_line = 485;   // R7 resync
            m_line = (m_line + 1) % 521;           // R3 wrap
            m_vsedge = b[7];
            m_ptr = 0;                             // R6 pointer reset
        end else begin
            m_ptr = (m_ptr + 1) % 256;             // R6 advance
        end
    endtask

    task automatic step(bit stb, logic [7:0] b, bit off);
        @(negedge clk);
        compare_all();
        pix_stb = stb;
        port_byte = b;
        rep_off = off;
        if (stb) model(b, off);
    endtask

    function automatic logic [7:0] make_byte(int line, int px);
        logic vs, hs;
        logic [5:0] col;
        vs = !((line % 600) >= 520 && (line % 600) < 523);
        hs = (px < 2);
        col = 6'((line * 7 + px * 13 + 5) & 63);
        return {vs, hs, col};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        m_line = 0; m_ptr = 0; m_prevhs = 1'b0; m_vsedge = 1'b1;
        e_col = '0; e_hs = 1'b0; e_vs = 1'b0; e_led = '0; e_dac = '0;
        e_tag = "R1 reset";
        // R1: drive junk while in reset, outputs must be zero
        port_byte = 8'hFF;
        pix_stb = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset colour", {2'b00, pix_col}, 8'h00);
        check("R1 reset hsync", {7'd0, hsync_o}, 8'h00);
        check("R1 reset vsync", {7'd0, vsync_o}, 8'h00);
        check("R1 reset led", {4'd0, led_o}, 8'h00);
        check("R1 reset dac", dac_o, 8'h00);
        pix_stb = 1'b0;
        port_byte = 8'h80;
        rst_n = 1'b1;
        // Partial line at counter 0 (hsync low) fills the buffer first
        for (int px = 0; px < LINE_PX; px++) begin
            step(1'b1, {2'b10, 6'(px * 5 + 1)}, 1'b0);
            step(1'b0, {2'b10, 6'(px * 5 + 1)}, 1'b0);
        end
        // Full frames: replay, resync (R7), wrap (R3), forced pass (R10)
        for (int line = 0; line < N_LINES; line++) begin
            bit off;
            off = (line >= 300 && line < 311) || (line == 900);
            for (int px = 0; px < LINE_PX; px++) begin
                logic [7:0] b;
                b = make_byte(line, px);
                step(1'b1, b, off);
                for (int g = 0; g < (px + line) % 3; g++) begin
                    step(1'b0, b, off);
                end
            end
        end
        step(1'b0, 8'h80, 1'b0);
        step(1'b0, 8'h80, 1'b0);
        summary();
        $finish;
    end
endmodule